// File: doc/BRIEF.md
# Unlocked Sector Program Controller

This block drives the program path of a byte-wide nonvolatile array that is organised as 256-byte sectors. It watches one-cycle write and read events on a shared address/data bus. Those events have already been synchronised and qualified upstream. A program operation opens only after a fixed three-write unlock sequence. While the load window is open, byte loads for one sector are gathered into a sector buffer. The window closes when loads stop arriving for a set number of clock cycles. The block then rewrites the whole sector with an implied erase: every byte that was not loaded becomes FFh. A timed internal program cycle follows, and during it reads return polling status instead of array data.

A write that does not fit the unlock sequence stores nothing, but it still starts the internal timer, so the host sees the same busy and polling behaviour either way. The controller is built around one state machine with four states. ST_IDLE waits for the unlock sequence. ST_LOAD collects loads. ST_PROG copies the buffer into the array while the busy timer runs. ST_DUMMY runs the busy timer with no data.

The transitions are:
- T_UNLOCKED: ST_IDLE to ST_LOAD.
- T_STRAY: ST_IDLE to ST_DUMMY.
- T_CLOSE: ST_LOAD to ST_PROG.
- T_EMPTY_CLOSE: ST_LOAD to ST_IDLE.
- T_PROG_DONE: ST_PROG to ST_IDLE.
- T_DUMMY_DONE: ST_DUMMY to ST_IDLE.

Only 2^SECT_IDX_W sectors are implemented. The stored array index uses the low bits of the sector field.

Top module: `sector_prog_ctl`

## Requirements
- R1: A write is counted only when wr_evt, ce_act and !oe_act hold together. The unlock sequence is three such writes, compared on address bits 14:0: data AAh to 5555h, then 55h to 2AAAh, then CMD_BYTE (default A0h) to 5555h. When the third write matches, the load window opens, and only data loaded after that is programmed.
- R2: In ST_IDLE, a counted write that is not the expected next unlock byte returns the tracker to its first step, stores no data, and holds busy high for a full program cycle.
- R3: The sector is given by address bits 14:4, and the byte offset within it is {addr[18:15], addr[3:0]}.
- R4: Loads may come in any order. A second load to the same offset replaces the first.
- R5: The window closes exactly LOAD_WIN cycles after the last accepted load, or after the third unlock write if no load has come. If a byte was loaded, busy rises at that edge.
- R6: The first load fixes the sector for the operation. A load that addresses a different sector (bits 14:4) is dropped and does not restart the window.
- R7: After programming, every byte of the sector that was not loaded reads FFh.
- R8: While busy, a read returns {~L[7], L[6:0]}, where L is the last accepted load, or the stray write for R2. After completion, a read returns the stored data.
- R9: busy stays high for exactly PROG_CYCLES cycles (PROG_CYCLES >= 257 for a program cycle).
- R10: A write event with oe_act high or ce_act low has no effect: no unlock progress and no busy.
- R11: Write events during busy are ignored, including any unlock progress.
- R12: A window that closes with no load returns to ST_IDLE without busy and leaves the array unchanged.
- R13: After reset, the block is in ST_IDLE with busy and rd_valid low.
- R14: rd_valid pulses, and rd_data is valid, in the cycle after a rd_evt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_evt | input | 1 | One-cycle write event |
| rd_evt | input | 1 | One-cycle read event |
| ce_act | input | 1 | Array chip enable active |
| oe_act | input | 1 | Output enable active (blocks writes) |
| bus_addr | input | 19 | Shared byte address |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result strobe |
| busy | output | 1 | Internal program or dummy cycle running |

## Verification
A tracker left at the wrong step shows at the ports within one write. Either a stray write raises busy in the next cycle, or a later valid sequence produces no busy after LOAD_WIN cycles. A wrong window count or a restart from a dropped load moves the busy rising edge off its exact cycle. A wrong busy count moves the falling edge. Buffer or merge errors, such as a wrong offset, a stale mask or missing FFh fill, appear only when the sector is read back after the program cycle. For that reason, every loaded, overwritten, dropped and unloaded offset is read back.

// File: rtl/scp_pkg.sv
package scp_pkg;

    localparam int ADDR_W       = 19;
    localparam int DATA_W       = 8;
    localparam int OFF_W        = 8;
    localparam int SECT_BYTES   = 1 << OFF_W;
    localparam int SECT_FIELD_W = 11;
    localparam int UNL_AW       = 15;

    localparam logic [UNL_AW-1:0] UNL_ADDR_ONE = 15'h5555;
    localparam logic [UNL_AW-1:0] UNL_ADDR_TWO = 15'h2AAA;
    localparam logic [DATA_W-1:0] UNL_DATA_ONE = 8'hAA;
    localparam logic [DATA_W-1:0] UNL_DATA_TWO = 8'h55;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_PROG,
        ST_DUMMY
    } ctl_state_t;

    typedef enum logic [1:0] {
        UL_STEP_ONE,
        UL_STEP_TWO,
        UL_STEP_THREE
    } unl_step_t;

endpackage

// File: rtl/scp_unlock.sv
module scp_unlock
    import scp_pkg::*;
#(
    parameter logic [7:0] CMD_BYTE = 8'hA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_ok,
    input  logic [UNL_AW-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              unlocked,
    output logic              stray
);

    unl_step_t         step_q;
    logic [UNL_AW-1:0] exp_addr;
    logic [DATA_W-1:0] exp_data;
    logic              hit;

    always_comb begin
        unique case (step_q)
            UL_STEP_ONE: begin
                exp_addr = UNL_ADDR_ONE;
                exp_data = UNL_DATA_ONE;
            end
            UL_STEP_TWO: begin
                exp_addr = UNL_ADDR_TWO;
                exp_data = UNL_DATA_TWO;
            end
            UL_STEP_THREE: begin
                exp_addr = UNL_ADDR_ONE;
                exp_data = CMD_BYTE;
            end
            default: begin
                exp_addr = UNL_ADDR_ONE;
                exp_data = UNL_DATA_ONE;
            end
        endcase
    end

    assign hit      = wr_ok && !clear && (addr == exp_addr) && (data == exp_data);
    assign unlocked = hit && (step_q == UL_STEP_THREE);
    assign stray    = wr_ok && !clear && !hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= UL_STEP_ONE;
        end else if (clear || stray) begin
            step_q <= UL_STEP_ONE;
        end else if (hit) begin
            unique case (step_q)
                UL_STEP_ONE:   step_q <= UL_STEP_TWO;
                UL_STEP_TWO:   step_q <= UL_STEP_THREE;
                UL_STEP_THREE: step_q <= UL_STEP_ONE;
                default:       step_q <= UL_STEP_ONE;
            endcase
        end
    end

    // R2: a mismatch always sends the tracker back to its first step
    p_stray_rewinds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stray |=> (step_q == UL_STEP_ONE));

    // R1: the final step is reached only through the second step
    p_step_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == UL_STEP_THREE && $past(step_q) != UL_STEP_THREE) |->
            ($past(step_q) == UL_STEP_TWO));

endmodule

// File: rtl/scp_interval_timer.sv
module scp_interval_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic expired
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && !restart && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R9: the count saturates at its last value and never runs past it
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q == LAST && !restart) |=> (!run || cnt_q == LAST || cnt_q == '0));

endmodule

// File: rtl/scp_sector_buf.sv
module scp_sector_buf
    import scp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    input  logic [OFF_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [OFF_W-1:0]  ridx,
    output logic [DATA_W-1:0] rbyte
);

    logic [DATA_W-1:0]     data_q [SECT_BYTES];
    logic [SECT_BYTES-1:0] loaded_q;

    always_ff @(posedge clk) begin
        if (we) begin
            data_q[widx] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            loaded_q <= '0;
        end else if (clear) begin
            loaded_q <= '0;
        end else if (we) begin
            loaded_q[widx] <= 1'b1;
        end
    end

    // implied erase: unloaded bytes come out as all ones
    assign rbyte = loaded_q[ridx] ? data_q[ridx] : {DATA_W{1'b1}};

    // R7: a cleared buffer holds no loaded byte in the next cycle
    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !we) |=> (loaded_q == '0));

endmodule

// File: rtl/sector_prog_ctl.sv
module sector_prog_ctl
    import scp_pkg::*;
#(
    parameter int          SECT_IDX_W  = 2,
    parameter int unsigned LOAD_WIN    = 37500,
    parameter int unsigned PROG_CYCLES = 2500000,
    parameter logic [7:0]  CMD_BYTE    = 8'hA0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_evt,
    input  logic        rd_evt,
    input  logic        ce_act,
    input  logic        oe_act,
    input  logic [18:0] bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  rd_data,
    output logic        rd_valid,
    output logic        busy
);

    localparam int SECT_CNT  = 1 << SECT_IDX_W;
    localparam int MEM_AW    = SECT_IDX_W + OFF_W;
    localparam int MEM_DEPTH = SECT_CNT * SECT_BYTES;

    ctl_state_t state_q, state_d;

    logic                    wr_ok;
    logic [SECT_FIELD_W-1:0] req_sect;
    logic [OFF_W-1:0]        req_off;
    logic [MEM_AW-1:0]       rd_index;

    logic                    unl_done, unl_stray, unl_clear;
    logic                    win_exp, bt_exp, bt_run;
    logic                    load_acc;

    logic                    have_sect_q;
    logic [SECT_FIELD_W-1:0] sect_q;
    logic [DATA_W-1:0]       last_q;
    logic [OFF_W-1:0]        copy_idx_q;
    logic                    copy_done_q;
    logic [DATA_W-1:0]       merged_byte;

    logic [DATA_W-1:0]       mem_q [MEM_DEPTH];
    logic                    mem_we;
    logic [MEM_AW-1:0]       mem_waddr;

    logic [DATA_W-1:0]       rd_data_q;
    logic                    rd_valid_q;
    logic                    busy_now;

    // bus decode
    assign wr_ok    = wr_evt && ce_act && !oe_act;
    assign req_sect = bus_addr[14:4];
    assign req_off  = {bus_addr[18:15], bus_addr[3:0]};
    assign rd_index = {bus_addr[4 +: SECT_IDX_W], req_off};

    // unlock tracker only listens while idle
    assign unl_clear = (state_q != ST_IDLE);

    scp_unlock #(
        .CMD_BYTE (CMD_BYTE)
    ) unlock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (unl_clear),
        .wr_ok    (wr_ok),
        .addr     (bus_addr[UNL_AW-1:0]),
        .data     (bus_wdata),
        .unlocked (unl_done),
        .stray    (unl_stray)
    );

    // load acceptance: first load fixes the sector, others must match it
    assign load_acc = (state_q == ST_LOAD) && wr_ok &&
                      (!have_sect_q || (req_sect == sect_q));

    scp_interval_timer #(
        .LIMIT (LOAD_WIN)
    ) win_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ST_LOAD),
        .restart (load_acc),
        .expired (win_exp)
    );

    assign bt_run = (state_q == ST_PROG) || (state_q == ST_DUMMY);

    scp_interval_timer #(
        .LIMIT (PROG_CYCLES)
    ) busy_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (bt_run),
        .restart (1'b0),
        .expired (bt_exp)
    );

    scp_sector_buf sbuf_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q == ST_IDLE),
        .we    (load_acc),
        .widx  (req_off),
        .wdata (bus_wdata),
        .ridx  (copy_idx_q),
        .rbyte (merged_byte)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (unl_done) begin
                    state_d = ST_LOAD;              // T_UNLOCKED
                end else if (unl_stray) begin
                    state_d = ST_DUMMY;             // T_STRAY
                end
            end
            ST_LOAD: begin
                if (win_exp) begin
                    state_d = have_sect_q ? ST_PROG // T_CLOSE
                                          : ST_IDLE; // T_EMPTY_CLOSE
                end
            end
            ST_PROG: begin
                if (bt_exp && copy_done_q) begin
                    state_d = ST_IDLE;              // T_PROG_DONE
                end
            end
            ST_DUMMY: begin
                if (bt_exp) begin
                    state_d = ST_IDLE;              // T_DUMMY_DONE
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // operation context: locked sector and last byte for polling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            have_sect_q <= 1'b0;
            sect_q      <= '0;
            last_q      <= '0;
        end else begin
            if (state_q == ST_IDLE) begin
                have_sect_q <= 1'b0;
                if (unl_stray) begin
                    last_q <= bus_wdata;
                end
            end else if (load_acc) begin
                have_sect_q <= 1'b1;
                sect_q      <= req_sect;
                last_q      <= bus_wdata;
            end
        end
    end

    // buffer to array copy, one byte per cycle during the program cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            copy_idx_q  <= '0;
            copy_done_q <= 1'b0;
        end else if (state_q != ST_PROG) begin
            copy_idx_q  <= '0;
            copy_done_q <= 1'b0;
        end else if (!copy_done_q) begin
            copy_idx_q <= copy_idx_q + 1'b1;
            if (copy_idx_q == OFF_W'(SECT_BYTES - 1)) begin
                copy_done_q <= 1'b1;
            end
        end
    end

    assign mem_we    = (state_q == ST_PROG) && !copy_done_q;
    assign mem_waddr = {sect_q[SECT_IDX_W-1:0], copy_idx_q};

    always_ff @(posedge clk) begin
        if (mem_we) begin
            mem_q[mem_waddr] <= merged_byte;
        end
    end

    // read path: polling while busy, array data otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_evt;
            if (rd_evt) begin
                rd_data_q <= busy_now ? {~last_q[7], last_q[6:0]}
                                      : mem_q[rd_index];
            end
        end
    end

    // outputs
    always_comb begin
        busy_now = (state_q == ST_PROG) || (state_q == ST_DUMMY);
        busy     = busy_now;
        rd_data  = rd_data_q;
        rd_valid = rd_valid_q;
    end

    // R1: the load window opens only on a completed unlock
    p_load_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && $past(state_q) == ST_IDLE) |-> $past(unl_done));

    // R2: a stray write in idle starts the busy period
    p_stray_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && unl_stray) |=> busy);

    // R5: window expiry with data starts programming
    p_close_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && win_exp && have_sect_q) |=> (state_q == ST_PROG));

    // R6: a load to a foreign sector leaves the polling byte untouched
    p_foreign_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && have_sect_q && wr_ok && req_sect != sect_q)
            |=> $stable(last_q));

    // R7: programming never ends before the whole sector is copied
    p_copy_complete_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PROG && !copy_done_q) |=> (state_q == ST_PROG));

    // R8: polling shows bit 7 inverted
    p_poll_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && busy) |=> (rd_valid && rd_data[7] != last_q[7]));

    // R10: blocked writes never leave idle
    p_blocked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_evt && (oe_act || !ce_act)) |=> (state_q == ST_IDLE));

    // R11: writes during busy change nothing visible
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wr_evt) |=> $stable(last_q));

    // R12: an empty window goes straight back to idle
    p_empty_close_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && win_exp && !have_sect_q) |=> (state_q == ST_IDLE));

    // R14: every read is answered in the next cycle
    p_read_answer_r14: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |=> rd_valid);

endmodule

// File: tb/sector_prog_ctl_tb_top.sv
`timescale 1ns/1ps
module sector_prog_ctl_tb_top;

    localparam int unsigned WIN  = 16;
    localparam int unsigned PROG = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_evt = 1'b0;
    logic        rd_evt = 1'b0;
    logic        ce_act = 1'b1;
    logic        oe_act = 1'b0;
    logic [18:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic        busy;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    sector_prog_ctl #(
        .SECT_IDX_W  (2),
        .LOAD_WIN    (WIN),
        .PROG_CYCLES (PROG),
        .CMD_BYTE    (8'hA0)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_evt    (wr_evt),
        .rd_evt    (rd_evt),
        .ce_act    (ce_act),
        .oe_act    (oe_act),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .busy      (busy)
    );

    // readback table after the sector 1 operation: {address, expected}
    localparam logic [26:0] RD_VEC [8] = '{
        {19'h00010, 8'h81},   // R3 offset 00
        {19'h00015, 8'hC7},   // R4 overwritten offset
        {19'h50013, 8'h5A},   // R3 high offset bits
        {19'h18013, 8'hFF},   // R3/R7 other high bits, unloaded
        {19'h00016, 8'hFF},   // R7 unloaded
        {19'h7801F, 8'hFF},   // R7 offset FF
        {19'h00027, 8'h22},   // R6 dropped load left sector 2 alone
        {19'h00020, 8'hFF}    // R7 sector 2 fill
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d,
                      input logic ce = 1'b1, input logic oe = 1'b0);
        bus_addr  = a;
        bus_wdata = d;
        ce_act    = ce;
        oe_act    = oe;
        wr_evt    = 1'b1;
        @(negedge clk);
        wr_evt    = 1'b0;
        ce_act    = 1'b1;
        oe_act    = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [18:0] a, input logic [7:0] exp);
        bus_addr = a;
        rd_evt   = 1'b1;
        @(negedge clk);
        rd_evt   = 1'b0;
        check("R14 rd_valid", {7'd0, rd_valid}, 8'd1);
        check(req, rd_data, exp);
    endtask

    task automatic unlock();
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'hA0);
    endtask

    task automatic wait_busy_fall();
        for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    endtask

    task automatic wait_busy_rise();
        for (int i = 0; i < 200 && !busy; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic saw_busy;
        repeat (3) @(negedge clk);
        // R13 reset state
        check("R13 busy", {7'd0, busy}, 8'd0);
        check("R13 rd_valid", {7'd0, rd_valid}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: blocked writes in the middle of an unlock
        wr(19'h05555, 8'hAA);
        wr(19'h01234, 8'h00, 1'b1, 1'b1);
        wr(19'h01234, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        check("R10 busy after blocked writes", {7'd0, busy}, 8'd0);
        wr(19'h02AAA, 8'h55);
        wr(19'h05555, 8'hA0);
        wr(19'h00027, 8'h22);
        wait_busy_rise();
        check("R1 busy after unlock+load", {7'd0, busy}, 8'd1);
        wait_busy_fall();
        rd_chk("R1 programmed byte", 19'h00027, 8'h22);
        rd_chk("R7 unloaded byte", 19'h00020, 8'hFF);

        // main operation on sector 1
        unlock();
        wr(19'h00015, 8'h3C);
        wr(19'h00010, 8'h81);
        wr(19'h50013, 8'h5A);
        wr(19'h00015, 8'hC7);       // last accepted load, edge k
        wr(19'h00027, 8'h11);       // foreign sector, edge k+1, dropped
        repeat (WIN - 2) @(negedge clk);
        check("R5/R6 busy one cycle before close", {7'd0, busy}, 8'd0);
        @(negedge clk);
        check("R5 busy at close", {7'd0, busy}, 8'd1);
        rd_chk("R8 polling byte", 19'h00000, 8'h47);
        wr(19'h05555, 8'hAA);       // ignored while busy
        repeat (PROG - 3) @(negedge clk);
        check("R9 busy last cycle", {7'd0, busy}, 8'd1);
        @(negedge clk);
        check("R9 busy ended", {7'd0, busy}, 8'd0);
        wr(19'h02AAA, 8'h55);
        check("R11 write during busy ignored", {7'd0, busy}, 8'd1);
        wait_busy_fall();

        for (int i = 0; i < 8; i++) begin
            rd_chk($sformatf("R3/R4/R6/R7 table row %0d", i),
                   RD_VEC[i][26:8], RD_VEC[i][7:0]);
        end

        // R12: empty window
        unlock();
        saw_busy = 1'b0;
        for (int i = 0; i < int'(WIN) + 4; i++) begin
            @(negedge clk);
            if (busy) saw_busy = 1'b1;
        end
        check("R12 no busy on empty window", {7'd0, saw_busy}, 8'd0);
        rd_chk("R12 array unchanged", 19'h00010, 8'h81);

        // R2: stray write
        wr(19'h00010, 8'h99);
        check("R2 stray write busy", {7'd0, busy}, 8'd1);
        rd_chk("R8 stray polling", 19'h00010, 8'h19);
        wait_busy_fall();
        rd_chk("R2 no data stored", 19'h00010, 8'h81);

        // R2: mismatch at the third step
        wr(19'h05555, 8'hAA);
        wr(19'h02AAA, 8'h55);
        check("R2 partial unlock idle", {7'd0, busy}, 8'd0);
        wr(19'h05555, 8'h80);
        check("R2 wrong command busy", {7'd0, busy}, 8'd1);
        wait_busy_fall();

        // fresh unlock after rewind, zero byte
        unlock();
        wr(19'h00030, 8'h00);
        wait_busy_rise();
        rd_chk("R8 polling bit7 set", 19'h00030, 8'h80);
        wait_busy_fall();
        rd_chk("R1 sector 3 byte", 19'h00030, 8'h00);
        rd_chk("R7 sector 3 fill", 19'h00031, 8'hFF);

        finish_run();
    end

endmodule